// File: doc/BRIEF.md
# Cipher Accelerator Control Sequencer

This unit is the register-mapped front end of a block-cipher datapath. Software stores the key length and direction, the chaining mode, the key words, a block count and a counter-increment select. A write to the trigger register then starts the sequencer. It hands the cipher engine one start pulse per 16-byte block and waits for the engine's done pulse before it issues the next one. When the sampled count reaches zero the status reads done. The interrupt flag is raised at that point and stays up until software clears it.

In authenticated (GCM) mode the first engine run derives the hash subkey. The unit captures that 128-bit result into readable words and then holds. It moves on only when software writes the continue register, and only then does it process the data blocks. A write to the exit register takes the unit from done back to idle. The cipher rounds live in an external engine with a fixed latency. Descriptor fetch is handled elsewhere.

Top module: `cipher_seq`

## Requirements
- R1: After reset the status reads idle (code 0), no engine start is issued, the interrupt output is low and all configuration registers read 0.
- R2: The mode register (word 0x00) holds a 3-bit code. Bits [1:0] select the key length (0 = 128, 1 = 192, 2 = 256 bits) and bit 2 selects decryption, so decryption adds 4 to the code. The code drives the engine's key-length and direction outputs directly.
- R3: A mode write whose bits [1:0] equal 3 names an unsupported key length and is dropped, leaving the stored code unchanged.
- R4: The chaining register (word 0x01) takes 0 = ECB, 1 = CBC, 2 = OFB, 3 = CTR, 4 = CFB8, 5 = CFB128 and 6 = GCM. A write of 7 is dropped.
- R5: Writing 1 in bit 0 of the trigger register (word 0x03) while idle samples the block count (word 0x02) and sets the status to running (code 1). The unit then issues exactly that many engine starts. Each start after the first waits for the engine's done pulse from the one before it. After the last done the status reads done (code 2). A count of 0 goes straight to done without any start.
- R6: A trigger while not idle is ignored, and a block-count write after a trigger does not change the run in progress.
- R7: With GCM selected, a trigger first issues one start marked as the hash-subkey run (status code 3). Its done captures the engine result into words 0x0C..0x0F, with word 0x0C holding bits 31:0. The unit then holds in status code 4 with no further starts until bit 0 of the continue register (word 0x05) is written. After that it processes the sampled block count as in R5.
- R7b: A continue with a sampled count of 0 goes straight to done.
- R8: Bit 0 of the exit register (word 0x06) returns the unit from done to idle. An exit outside done and a continue outside the hold state are ignored.
- R9: Writes to the mode, chaining, increment-select and key registers (words 0x10..0x17, word 0x10 = key bits 31:0) are ignored while the status is not idle.
- R10: Entering done sets an interrupt flag, which reads at word 0x08 bit 0. The interrupt output is that flag ANDed with the enable bit (word 0x07 bit 0). Writing 1 to word 0x08 clears the flag, but a set in the same cycle wins over the clear.
- R11: The increment-select register (word 0x09 bit 0) at 0 drives the low-32-bit counter output high; at 1 it drives it low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 5 | Register word address (read and write) |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| eng_start_o | output | 1 | One-cycle start pulse to the cipher engine |
| eng_hash_o | output | 1 | Marks the current engine run as hash-subkey derivation |
| eng_done_i | input | 1 | Engine done pulse |
| eng_h_i | input | 128 | Engine result captured as the hash subkey |
| eng_key_o | output | 256 | Key words to the engine |
| eng_keylen_o | output | 2 | Key length code |
| eng_decrypt_o | output | 1 | Decrypt direction |
| eng_chain_o | output | 3 | Chaining mode code |
| eng_ctr_low32_o | output | 1 | Counter increments only its low 32 bits |
| irq_o | output | 1 | Completion interrupt |

## Verification
The bench checks a count of zero in both plain and GCM runs. A design that decrements before testing would wrap the counter and issue thousands of starts. The bench also checks the GCM hold against stray exit and continue writes, and it fires triggers, block-count writes and key writes during a busy run. A sequencer that re-sampled or accepted them would change the number of starts or the key. It also rejects the unsupported key and chaining codes and checks the interrupt across clear and re-enable. A flag wired as a pulse, or a clear that wins over a set, shows up as a low interrupt after done.

// File: rtl/cseq_pkg.sv
package cseq_pkg;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int unsigned ADDR_W = 5;

  localparam logic [ADDR_W-1:0] A_MODE    = 5'h00;
  localparam logic [ADDR_W-1:0] A_CHAIN   = 5'h01;
  localparam logic [ADDR_W-1:0] A_BLKNUM  = 5'h02;
  localparam logic [ADDR_W-1:0] A_TRIG    = 5'h03;
  localparam logic [ADDR_W-1:0] A_STATUS  = 5'h04;
  localparam logic [ADDR_W-1:0] A_CONT    = 5'h05;
  localparam logic [ADDR_W-1:0] A_EXIT    = 5'h06;
  localparam logic [ADDR_W-1:0] A_IRQ_EN  = 5'h07;
  localparam logic [ADDR_W-1:0] A_IRQ_CLR = 5'h08;
  localparam logic [ADDR_W-1:0] A_INC     = 5'h09;
  localparam logic [ADDR_W-1:0] A_H       = 5'h0C;
  localparam logic [ADDR_W-1:0] A_KEY     = 5'h10;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_RUN   = 3'd1,
    ST_DONE  = 3'd2,
    ST_HASH  = 3'd3,
    ST_HWAIT = 3'd4
  } seq_state_e;

  typedef enum logic [2:0] {
    CH_ECB    = 3'd0,
    CH_CBC    = 3'd1,
    CH_OFB    = 3'd2,
    CH_CTR    = 3'd3,
    CH_CFB8   = 3'd4,
    CH_CFB128 = 3'd5,
    CH_GCM    = 3'd6
  } chain_e;
endpackage

// File: rtl/cseq_regs.sv
module cseq_regs
  import cseq_pkg::*;
#(
  parameter int unsigned DW        = 32,
  parameter int unsigned KEY_WORDS = 8,
  parameter int unsigned CNT_W     = 16,
  parameter int unsigned H_W       = 128
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    wr_en_i,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [DW-1:0]           wdata_i,
  input  logic                    idle_i,
  input  seq_state_e              state_i,
  input  logic                    irq_flag_i,
  input  logic [H_W-1:0]          h_i,
  output logic [DW-1:0]           rdata_o,
  output logic [KEY_WORDS*DW-1:0] key_o,
  output logic [1:0]              keylen_o,
  output logic                    decrypt_o,
  output chain_e                  chain_o,
  output logic                    ctr_low32_o,
  output logic                    irq_en_o,
  output logic [CNT_W-1:0]        blknum_o,
  output logic                    trig_o,
  output logic                    cont_o,
  output logic                    exit_o,
  output logic                    iclr_o
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam int unsigned H_WORDS = H_W / DW;
  localparam int unsigned HIDX_W  = $clog2(H_WORDS);
  localparam int unsigned KIDX_W  = $clog2(KEY_WORDS);

  logic [KEY_WORDS-1:0][DW-1:0] key_q;
  logic [H_WORDS-1:0][DW-1:0]   h_words;
  logic [2:0]                   mode_q;
  chain_e                       chain_q;
  logic                         inc_q, ien_q;
  logic [CNT_W-1:0]             blk_q;
  logic                         cfg_we;
  logic [HIDX_W-1:0]            hidx;
  logic [KIDX_W-1:0]            kidx;
  logic                         in_h, in_key;

  assign h_words = h_i;
  assign cfg_we  = wr_en_i && idle_i;
  assign hidx    = HIDX_W'(addr_i - A_H);
  assign kidx    = KIDX_W'(addr_i - A_KEY);
  assign in_h    = (addr_i >= A_H) && (addr_i < A_H + ADDR_W'(H_WORDS));
  assign in_key  = (addr_i >= A_KEY) && (addr_i < A_KEY + ADDR_W'(KEY_WORDS));

  assign trig_o = wr_en_i && (addr_i == A_TRIG)    && wdata_i[0];
  assign cont_o = wr_en_i && (addr_i == A_CONT)    && wdata_i[0];
  assign exit_o = wr_en_i && (addr_i == A_EXIT)    && wdata_i[0];
  assign iclr_o = wr_en_i && (addr_i == A_IRQ_CLR) && wdata_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= '0;
      chain_q <= CH_ECB;
      inc_q   <= 1'b0;
      ien_q   <= 1'b0;
      blk_q   <= '0;
    end else begin
      // unsupported key length code 3 is dropped
      if (cfg_we && addr_i == A_MODE && wdata_i[1:0] != 2'b11) mode_q <= wdata_i[2:0];
      if (cfg_we && addr_i == A_CHAIN && wdata_i[2:0] != 3'd7) chain_q <= chain_e'(wdata_i[2:0]);
      if (cfg_we && addr_i == A_INC) inc_q <= wdata_i[0];
      if (wr_en_i && addr_i == A_IRQ_EN) ien_q <= wdata_i[0];
      // count is sampled by the sequencer at trigger, so always writable
      if (wr_en_i && addr_i == A_BLKNUM) blk_q <= wdata_i[CNT_W-1:0];
    end
  end

  for (genvar k = 0; k < KEY_WORDS; k++) begin : g_key
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) key_q[k] <= '0;
      else if (cfg_we && addr_i == A_KEY + ADDR_W'(k)) key_q[k] <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_MODE:    rdata_o[2:0] = mode_q;
      A_CHAIN:   rdata_o[2:0] = chain_q;
      A_BLKNUM:  rdata_o[CNT_W-1:0] = blk_q;
      A_STATUS:  rdata_o[2:0] = state_i;
      A_IRQ_EN:  rdata_o[0] = ien_q;
      A_IRQ_CLR: rdata_o[0] = irq_flag_i;
      A_INC:     rdata_o[0] = inc_q;
      default: begin
        if (in_h) rdata_o = h_words[hidx];
        else if (in_key) rdata_o = key_q[kidx];
      end
    endcase
  end

  assign key_o       = key_q;
  assign keylen_o    = mode_q[1:0];
  assign decrypt_o   = mode_q[2];
  assign chain_o     = chain_q;
  assign ctr_low32_o = ~inc_q;
  assign irq_en_o    = ien_q;
  assign blknum_o    = blk_q;

  // R3
  mode_reject_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == A_MODE && wdata_i[1:0] == 2'b11) |=> $stable(mode_q));
  // R9
  key_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !idle_i) |=> ($stable(key_o) && $stable(mode_q) && $stable(chain_q)));
endmodule

// File: rtl/cseq_fsm.sv
module cseq_fsm
  import cseq_pkg::*;
#(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned H_W   = 128
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             trig_i,
  input  logic             cont_i,
  input  logic             exit_i,
  input  logic             gcm_i,
  input  logic [CNT_W-1:0] blknum_i,
  input  logic             eng_done_i,
  input  logic [H_W-1:0]   eng_h_i,
  output seq_state_e       state_o,
  output logic             eng_start_o,
  output logic             eng_hash_o,
  output logic             done_evt_o,
  output logic [H_W-1:0]   h_o
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  seq_state_e       st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             infl_q, infl_d;
  logic [H_W-1:0]   h_q, h_d;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    infl_d = infl_q;
    h_d    = h_q;
    unique case (st_q)
      ST_IDLE: if (trig_i) begin
        cnt_d = blknum_i;
        if (gcm_i)               st_d = ST_HASH;
        else if (blknum_i == '0) st_d = ST_DONE;
        else                     st_d = ST_RUN;
      end
      ST_RUN, ST_HASH: begin
        if (!infl_q) infl_d = 1'b1;
        else if (eng_done_i) begin
          infl_d = 1'b0;
          if (st_q == ST_HASH) begin
            h_d  = eng_h_i;
            st_d = ST_HWAIT;
          end else begin
            cnt_d = cnt_q - CNT_ONE;
            if (cnt_q == CNT_ONE) st_d = ST_DONE;
          end
        end
      end
      ST_HWAIT: if (cont_i) st_d = (cnt_q == '0) ? ST_DONE : ST_RUN;
      ST_DONE:  if (exit_i) st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      infl_q <= 1'b0;
      h_q    <= '0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      infl_q <= infl_d;
      h_q    <= h_d;
    end
  end

  assign state_o     = st_q;
  assign eng_start_o = (st_q == ST_RUN || st_q == ST_HASH) && !infl_q;
  assign eng_hash_o  = (st_q == ST_HASH);
  assign done_evt_o  = (st_d == ST_DONE) && (st_q != ST_DONE);
  assign h_o         = h_q;

  // R5
  start_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_start_o |=> !eng_start_o);
  // R6
  trig_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o != ST_IDLE && trig_i && !exit_i) |=> state_o != ST_IDLE);
  // R7
  hwait_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == ST_HWAIT && !cont_i) |=> (state_o == ST_HWAIT && !eng_start_o));
  // R8
  exit_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == ST_DONE && exit_i) |=> state_o == ST_IDLE);
endmodule

// File: rtl/cseq_irq.sv
module cseq_irq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  input  logic en_i,
  output logic flag_o,
  output logic irq_o
);
  timeunit 1ns;
  timeprecision 1ps;

  logic flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    flag_q <= 1'b0;
    else if (set_i) flag_q <= 1'b1;
    else if (clr_i) flag_q <= 1'b0;
  end

  assign flag_o = flag_q;
  assign irq_o  = flag_q & en_i;

  // R10
  irq_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> flag_o);
endmodule

// File: rtl/cipher_seq.sv
module cipher_seq
  import cseq_pkg::*;
#(
  parameter int unsigned DW        = 32,
  parameter int unsigned KEY_WORDS = 8,
  parameter int unsigned CNT_W     = 16,
  parameter int unsigned H_W       = 128
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    wr_en_i,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [DW-1:0]           wdata_i,
  output logic [DW-1:0]           rdata_o,
  output logic                    eng_start_o,
  output logic                    eng_hash_o,
  input  logic                    eng_done_i,
  input  logic [H_W-1:0]          eng_h_i,
  output logic [KEY_WORDS*DW-1:0] eng_key_o,
  output logic [1:0]              eng_keylen_o,
  output logic                    eng_decrypt_o,
  output logic [2:0]              eng_chain_o,
  output logic                    eng_ctr_low32_o,
  output logic                    irq_o
);
  timeunit 1ns;
  timeprecision 1ps;

  seq_state_e       state;
  chain_e           chain;
  logic [CNT_W-1:0] blknum;
  logic [H_W-1:0]   h_val;
  logic             trig, cont, ext, iclr, irq_en, irq_flag, done_evt;

  cseq_regs #(.DW(DW), .KEY_WORDS(KEY_WORDS), .CNT_W(CNT_W), .H_W(H_W)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .addr_i, .wdata_i,
    .idle_i      (state == ST_IDLE),
    .state_i     (state),
    .irq_flag_i  (irq_flag),
    .h_i         (h_val),
    .rdata_o,
    .key_o       (eng_key_o),
    .keylen_o    (eng_keylen_o),
    .decrypt_o   (eng_decrypt_o),
    .chain_o     (chain),
    .ctr_low32_o (eng_ctr_low32_o),
    .irq_en_o    (irq_en),
    .blknum_o    (blknum),
    .trig_o      (trig),
    .cont_o      (cont),
    .exit_o      (ext),
    .iclr_o      (iclr)
  );

  cseq_fsm #(.CNT_W(CNT_W), .H_W(H_W)) u_fsm (
    .clk_i, .rst_ni,
    .trig_i      (trig),
    .cont_i      (cont),
    .exit_i      (ext),
    .gcm_i       (chain == CH_GCM),
    .blknum_i    (blknum),
    .eng_done_i,
    .eng_h_i,
    .state_o     (state),
    .eng_start_o,
    .eng_hash_o,
    .done_evt_o  (done_evt),
    .h_o         (h_val)
  );

  cseq_irq u_irq (
    .clk_i, .rst_ni,
    .set_i  (done_evt),
    .clr_i  (iclr),
    .en_i   (irq_en),
    .flag_o (irq_flag),
    .irq_o
  );

  assign eng_chain_o = chain;
endmodule

// File: tb/test_cipher_seq.sv
module test_cipher_seq;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int LAT = 4;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         wr_en_i = 1'b0;
  logic [4:0]   addr_i = '0;
  logic [31:0]  wdata_i = '0;
  logic [31:0]  rdata_o;
  logic         eng_start_o, eng_hash_o;
  logic         eng_done_i = 1'b0;
  logic [127:0] eng_h_i = 128'h0;
  logic [255:0] eng_key_o;
  logic [1:0]   eng_keylen_o;
  logic         eng_decrypt_o;
  logic [2:0]   eng_chain_o;
  logic         eng_ctr_low32_o, irq_o;

  int n_chk = 0, n_fail = 0, cyc = 0, eng_t = 0;
  int start_cnt = 0, hash_cnt = 0;
  bit finished = 1'b0;

  // reference model state
  int m_st = 0, m_cnt = 0, m_infl = 0, m_mode = 0, m_chain = 0, m_blk = 0, m_inc = 0, m_ien = 0, m_flag = 0;
  logic [127:0] m_h = '0;
  logic [31:0]  m_key [8];

  cipher_seq i_cipher_seq (
    .clk_i(clk), .rst_ni, .wr_en_i, .addr_i, .wdata_i, .rdata_o,
    .eng_start_o, .eng_hash_o, .eng_done_i, .eng_h_i, .eng_key_o,
    .eng_keylen_o, .eng_decrypt_o, .eng_chain_o, .eng_ctr_low32_o, .irq_o
  );

  always #2.5 clk = ~clk;

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  task automatic chk(input bit ok, input string tag, input logic [255:0] act, input logic [255:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_rd(input logic [4:0] a);
    int ai = int'(a);
    if (ai == 0) return 32'(m_mode);
    if (ai == 1) return 32'(m_chain);
    if (ai == 2) return 32'(m_blk);
    if (ai == 4) return 32'(m_st);
    if (ai == 7) return 32'(m_ien);
    if (ai == 8) return 32'(m_flag);
    if (ai == 9) return 32'(m_inc);
    if (ai >= 12 && ai < 16) return m_h[(ai-12)*32 +: 32];
    if (ai >= 16 && ai < 24) return m_key[ai-16];
    return 32'h0;
  endfunction

  // behavioural reference, advanced on each rising edge
  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_st = 0; m_cnt = 0; m_infl = 0; m_mode = 0; m_chain = 0; m_blk = 0;
      m_inc = 0; m_ien = 0; m_flag = 0; m_h = '0;
      for (int i = 0; i < 8; i++) m_key[i] = '0;
    end else begin
      int a, nst;
      bit trig, cont, ex, clr, idle;
      a = int'(addr_i);
      idle = (m_st == 0);
      trig = wr_en_i && a == 3 && wdata_i[0];
      cont = wr_en_i && a == 5 && wdata_i[0];
      ex   = wr_en_i && a == 6 && wdata_i[0];
      clr  = wr_en_i && a == 8 && wdata_i[0];
      nst = m_st;
      case (m_st)
        0: if (trig) begin
             m_cnt = m_blk;
             nst = (m_chain == 6) ? 3 : (m_blk == 0) ? 2 : 1;
           end
        1, 3: begin
          if (m_infl == 0) m_infl = 1;
          else if (eng_done_i) begin
            m_infl = 0;
            if (m_st == 3) begin m_h = eng_h_i; nst = 4; end
            else begin m_cnt = m_cnt - 1; if (m_cnt == 0) nst = 2; end
          end
        end
        4: if (cont) nst = (m_cnt == 0) ? 2 : 1;
        2: if (ex) nst = 0;
        default: nst = 0;
      endcase
      if (nst == 2 && m_st != 2) m_flag = 1;
      else if (clr) m_flag = 0;
      if (wr_en_i) begin
        if (a == 2) m_blk = int'(wdata_i[15:0]);
        if (a == 7) m_ien = int'(wdata_i[0]);
        if (idle) begin
          if (a == 0 && wdata_i[1:0] != 2'b11) m_mode = int'(wdata_i[2:0]);
          if (a == 1 && wdata_i[2:0] != 3'd7) m_chain = int'(wdata_i[2:0]);
          if (a == 9) m_inc = int'(wdata_i[0]);
          if (a >= 16 && a < 24) m_key[a-16] = wdata_i;
        end
      end
      m_st = nst;
    end
  end

  // engine with fixed latency, start counters
  always @(negedge clk) begin
    eng_done_i <= 1'b0;
    if (eng_t > 0) begin
      eng_t--;
      if (eng_t == 0) eng_done_i <= 1'b1;
    end
    if (eng_start_o) begin
      eng_t = LAT;
      start_cnt++;
      if (eng_hash_o) hash_cnt++;
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_ni && !finished) begin
      logic [255:0] k;
      bit xs, xh, xi;
      for (int i = 0; i < 8; i++) k[i*32 +: 32] = m_key[i];
      xs = (m_st == 1 || m_st == 3) && m_infl == 0;
      xh = (m_st == 3);
      xi = (m_flag != 0) && (m_ien != 0);
      chk(eng_start_o == xs, "R5 start", 256'(eng_start_o), 256'(xs));
      chk(eng_hash_o == xh, "R7 hash", 256'(eng_hash_o), 256'(xh));
      chk(irq_o == xi, "R10 irq", 256'(irq_o), 256'(xi));
      chk(eng_keylen_o == 2'(m_mode) && eng_decrypt_o == m_mode[2], "R2 mode out",
          256'({eng_decrypt_o, eng_keylen_o}), 256'(m_mode));
      chk(eng_chain_o == 3'(m_chain), "R4 chain out", 256'(eng_chain_o), 256'(m_chain));
      chk(eng_ctr_low32_o == (m_inc == 0), "R11 ctr", 256'(eng_ctr_low32_o), 256'(m_inc == 0));
      chk(eng_key_o == k, "R9 key out", eng_key_o, k);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000 && !finished) begin
      finished = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=0", cyc);
      summary();
      $finish;
    end
  end

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, input logic [31:0] expv, input string tag);
    logic [31:0] v;
    @(negedge clk);
    wr_en_i = 1'b0; addr_i = a;
    #1;
    v = rdata_o;
    chk(v == exp_rd(a), {tag, " model"}, 256'(v), 256'(exp_rd(a)));
    chk(v == expv, tag, 256'(v), 256'(expv));
  endtask

  task automatic wait_status(input logic [31:0] code, input string tag);
    logic [31:0] v;
    v = '1;
    for (int i = 0; i < 300 && v != code; i++) begin
      @(negedge clk);
      wr_en_i = 1'b0; addr_i = 5'h04;
      #1;
      v = rdata_o;
    end
    chk(v == code, tag, 256'(v), 256'(code));
  endtask

  initial begin
    int s0, h0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // R1 reset state
    rd(5'h04, 0, "R1 status idle");
    rd(5'h00, 0, "R1 mode zero");
    chk(irq_o == 1'b0 && eng_start_o == 1'b0, "R1 outputs low", 256'({irq_o, eng_start_o}), 0);

    // R2 / R3 key length and direction
    wr(5'h00, 6);
    rd(5'h00, 6, "R2 mode 256 decrypt");
    chk(eng_keylen_o == 2 && eng_decrypt_o, "R2 engine mode", 256'({eng_decrypt_o, eng_keylen_o}), 6);
    wr(5'h00, 3);
    rd(5'h00, 6, "R3 code 3 rejected");
    wr(5'h00, 7);
    rd(5'h00, 6, "R3 code 7 rejected");
    wr(5'h00, 1);
    rd(5'h00, 1, "R2 mode 192 encrypt");

    // R4 chaining, R11 increment select
    wr(5'h01, 3);
    rd(5'h01, 3, "R4 chain CTR");
    wr(5'h01, 7);
    rd(5'h01, 3, "R4 code 7 rejected");
    wr(5'h09, 1);
    chk(eng_ctr_low32_o == 1'b0, "R11 full increment", 256'(eng_ctr_low32_o), 0);
    wr(5'h09, 0);
    chk(eng_ctr_low32_o == 1'b1, "R11 low 32 increment", 256'(eng_ctr_low32_o), 1);

    for (int i = 0; i < 8; i++) wr(5'(16 + i), 32'hA5000000 + 32'(i));
    rd(5'h13, 32'hA5000003, "R9 key readback");

    // R5 / R6 / R9 / R10 plain run of three blocks
    wr(5'h01, 0);
    wr(5'h07, 1);
    wr(5'h02, 3);
    s0 = start_cnt;
    wr(5'h03, 1);
    wr(5'h10, 32'hDEADBEEF);
    wr(5'h00, 2);
    wr(5'h03, 1);
    wr(5'h02, 9);
    wait_status(2, "R5 reaches done");
    chk(start_cnt - s0 == 3, "R5 R6 three starts", 256'(start_cnt - s0), 3);
    rd(5'h10, 32'hA5000000, "R9 key write while busy ignored");
    rd(5'h00, 1, "R9 mode write while busy ignored");
    chk(irq_o == 1'b1, "R10 irq after done", 256'(irq_o), 1);
    wr(5'h05, 1);
    rd(5'h04, 2, "R8 continue outside hold ignored");
    wr(5'h08, 1);
    chk(irq_o == 1'b0, "R10 cleared", 256'(irq_o), 0);
    wr(5'h06, 1);
    rd(5'h04, 0, "R8 exit to idle");

    // R5 zero blocks
    wr(5'h02, 0);
    s0 = start_cnt;
    wr(5'h03, 1);
    rd(5'h04, 2, "R5 zero count done");
    chk(start_cnt == s0, "R5 zero count no start", 256'(start_cnt - s0), 0);
    wr(5'h07, 0);
    chk(irq_o == 1'b0, "R10 masked", 256'(irq_o), 0);
    wr(5'h07, 1);
    chk(irq_o == 1'b1, "R10 unmasked", 256'(irq_o), 1);
    wr(5'h08, 1);
    wr(5'h06, 1);
    wr(5'h06, 1);
    rd(5'h04, 0, "R8 exit in idle ignored");

    // R7 authenticated mode
    eng_h_i = 128'h0F1E2D3C_4B5A6978_8796A5B4_C3D2E1F0;
    wr(5'h01, 6);
    wr(5'h02, 2);
    s0 = start_cnt; h0 = hash_cnt;
    wr(5'h03, 1);
    wait_status(4, "R7 holds after subkey");
    chk(start_cnt - s0 == 1 && hash_cnt - h0 == 1, "R7 one hash start",
        256'(start_cnt - s0), 1);
    rd(5'h0C, 32'hC3D2E1F0, "R7 subkey word0");
    rd(5'h0F, 32'h0F1E2D3C, "R7 subkey word3");
    eng_h_i = '0;
    repeat (10) @(negedge clk);
    wr(5'h06, 1);
    rd(5'h04, 4, "R8 exit during hold ignored");
    chk(start_cnt - s0 == 1, "R7 no start while holding", 256'(start_cnt - s0), 1);
    wr(5'h05, 1);
    wait_status(2, "R7 done after continue");
    chk(start_cnt - s0 == 3 && hash_cnt - h0 == 1, "R7 two data starts",
        256'(start_cnt - s0), 3);
    rd(5'h0C, 32'hC3D2E1F0, "R7 subkey kept");
    wr(5'h08, 1);
    wr(5'h06, 1);

    // R7b authenticated, zero data blocks
    wr(5'h02, 0);
    s0 = start_cnt;
    wr(5'h03, 1);
    wait_status(4, "R7b hold with zero count");
    wr(5'h05, 1);
    rd(5'h04, 2, "R7b continue to done");
    chk(start_cnt - s0 == 1, "R7b only hash start", 256'(start_cnt - s0), 1);
    wr(5'h06, 1);
    rd(5'h04, 0, "R8 back to idle");

    finished = 1'b1;
    summary();
    $finish;
  end
endmodule